// File: doc/BRIEF.md
# Tick-Driven Watchdog Countdown Timer

This block is a watchdog that counts down a programmed number of slow ticks and, if software does not reload it in time, first raises an interrupt and then asks for a system reset. A prescaler divides the system clock into the tick. The count moves down by one on each tick while counting is enabled. A tick that arrives while the count is zero is an expiry, and the count then restarts from the programmed initial value.

Software drives the block through a 32-byte window of 16-bit registers, using byte addresses and separate read and write strobes. Address bit 0 is ignored, so each register occupies one even offset. Any write to the count register restarts the countdown. The control register holds a halt bit and a reset mask bit. The status register records a first timeout and a second timeout, and software clears each bit by writing a one to it.

The first expiry only warns software. An expiry that finds the warning still pending sets the second timeout bit. That bit asserts the reset request unless the reset mask bit is set.

Top module: `wdt_countdown`

## Requirements
- R1: After reset the control register reads 0x0801 (halt bit 11 = 1, reset mask bit 0 = 1), the initial-value register and the count register read 0x0004, the status register reads 0x0000, and irq and rstReq are low.
- R2: The initial-value register at offset 0x06 stores only write-data bits 9:0, and bits 15:10 always read 0. A write whose bits 9:0 hold a value from 0 to 3 is ignored, and the register keeps its old value.
- R3: A write of any data to offset 0x00 loads the count with the initial value. A read of offset 0x00 returns the count in bits 9:0, with bits 15:10 at 0.
- R4: Bit 11 of the control register at offset 0x04 reads back as written. While it is 1, the count and the prescaler do not change, except when a reload loads the count.
- R5: While the halt bit is 0, one tick occurs every TICK_DIV clocks, counted from the clock edge that cleared halt or wrote a reload. Each tick lowers a nonzero count by one. A tick at count 0 is an expiry that reloads the initial value, so from that edge an expiry lands (init+1)*TICK_DIV clocks later.
- R6: An expiry while status bit 0 is 0 sets status bit 0 and pulses irq high for exactly one clock.
- R7: An expiry while status bit 0 is 1 sets status bit 1 and does not pulse irq. rstReq is high whenever status bit 1 is 1 and the reset mask bit is 0.
- R8: Bit 0 of the control register is the reset mask. It reads back as written and holds rstReq low while it is 1, including after the second timeout has been recorded.
- R9: The status register at offset 0x02 is write-one-to-clear: bit 0 is the first timeout and bit 1 the second timeout. A write of 0 to a bit leaves it unchanged.
- R10: Read data is registered: rdData takes the addressed value on the clock edge that samples rdEn. Offsets 0x08 to 0x1E read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one write per cycle |
| rdEn | input | 1 | Read strobe |
| addr | input | 5 | Byte address within the 32-byte window |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data |
| irq | output | 1 | One-clock pulse on the first timeout |
| rstReq | output | 1 | System reset request, level |

## Verification
The hardest case to reach is the second expiry. It only happens when an expiry finds the first-timeout bit still set and the reset mask is clear, and it must be told apart from the path where software clears the warning in time.

The stimulus sets a small initial value with a divisor of four, clears both masks and waits. It checks the exact clock at which irq rises and then the exact clock at which rstReq rises. It then repeats the run, clearing the first-timeout bit between the two expiries, and checks that a second irq appears instead of a reset request.

Random writes to the initial-value register, with values on both sides of the floor of 4, and random reload data are mixed with these directed runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int IDX_W = ADDR_W - 1;

  // word indices (byte offset / 2)
  localparam logic [IDX_W-1:0] REG_COUNT   = 4'd0;
  localparam logic [IDX_W-1:0] REG_STATUS  = 4'd1;
  localparam logic [IDX_W-1:0] REG_CONTROL = 4'd2;
  localparam logic [IDX_W-1:0] REG_INIT    = 4'd3;

  localparam int HALT_BIT     = 11;
  localparam int NOREBOOT_BIT = 0;
  localparam int MIN_INIT     = 4;
  localparam int RESET_INIT   = 4;

  typedef struct packed {
    logic reload;
    logic clrFirst;
    logic clrSecond;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] divCnt;

  assign tick = run && (divCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (clear || !run || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  AST_PRESCALE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> divCnt == '0);  // R4
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              firstTo,
  input  logic              secondTo,
  output wdt_strobe_t       strobe,
  output logic              halt,
  output logic              noReboot,
  output logic [CNT_W-1:0]  initVal,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [IDX_W-1:0]  regIdx;
  logic [DATA_W-1:0] readMux;
  logic              initOk;

  assign regIdx = addr[ADDR_W-1:1];
  assign initOk = wrData[CNT_W-1:0] >= CNT_W'(MIN_INIT);

  always_comb begin
    strobe.reload    = wrEn && (regIdx == REG_COUNT);
    strobe.clrFirst  = wrEn && (regIdx == REG_STATUS) && wrData[0];
    strobe.clrSecond = wrEn && (regIdx == REG_STATUS) && wrData[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halt     <= 1'b1;
      noReboot <= 1'b1;
      initVal  <= CNT_W'(RESET_INIT);
    end else if (wrEn) begin
      case (regIdx)
        REG_CONTROL: begin
          halt     <= wrData[HALT_BIT];
          noReboot <= wrData[NOREBOOT_BIT];
        end
        REG_INIT: if (initOk) initVal <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    readMux = '0;
    case (regIdx)
      REG_COUNT:   readMux = {{PAD_W{1'b0}}, count};
      REG_STATUS:  readMux = {{(DATA_W-2){1'b0}}, secondTo, firstTo};
      REG_CONTROL: begin
        readMux[HALT_BIT]     = halt;
        readMux[NOREBOOT_BIT] = noReboot;
      end
      REG_INIT:    readMux = {{PAD_W{1'b0}}, initVal};
      default:     readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= readMux;
    end
  end

  AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    initVal >= CNT_W'(MIN_INIT));  // R2
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdt_strobe_t      strobe,
  input  logic             halt,
  input  logic             noReboot,
  input  logic [CNT_W-1:0] initVal,
  output logic [CNT_W-1:0] count,
  output logic             firstTo,
  output logic             secondTo,
  output logic             irq,
  output logic             rstReq
);
  logic tick;
  logic expiry;

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) prescaler (
    .clk  (clk),
    .rstN (rstN),
    .run  (!halt),
    .clear(strobe.reload),
    .tick (tick)
  );

  assign expiry = tick && !strobe.reload && (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= CNT_W'(RESET_INIT);
    end else if (strobe.reload || expiry) begin
      count <= initVal;
    end else if (tick) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstTo  <= 1'b0;
      secondTo <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= expiry && !firstTo;
      if (expiry && !firstTo)  firstTo <= 1'b1;
      else if (strobe.clrFirst) firstTo <= 1'b0;
      if (expiry && firstTo)    secondTo <= 1'b1;
      else if (strobe.clrSecond) secondTo <= 1'b0;
    end
  end

  assign rstReq = secondTo && !noReboot;

  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> count == $past(initVal));  // R3
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    halt && !strobe.reload |=> $stable(count));  // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);  // R6
  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secondTo) |-> $past(firstTo));  // R7
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 120000000,
  parameter int CNT_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              rstReq
);
  wdt_strobe_t      strobe;
  logic             halt;
  logic             noReboot;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] count;
  logic             firstTo;
  logic             secondTo;

  wdt_ctrl #(.CNT_W(CNT_W)) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrData  (wrData),
    .count   (count),
    .firstTo (firstTo),
    .secondTo(secondTo),
    .strobe  (strobe),
    .halt    (halt),
    .noReboot(noReboot),
    .initVal (initVal),
    .rdData  (rdData)
  );

  wdt_datapath #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .halt    (halt),
    .noReboot(noReboot),
    .initVal (initVal),
    .count   (count),
    .firstTo (firstTo),
    .secondTo(secondTo),
    .irq     (irq),
    .rstReq  (rstReq)
  );
endmodule

// File: tb/wdt_countdown_test.sv
`timescale 1ns/1ps
module wdt_countdown_test;
  localparam int DIV = 4;
  localparam int N   = 5;
  localparam int M   = (N + 1) * DIV;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;
  logic        rstReq;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;

  wdt_countdown #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .rstReq(rstReq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] nextInit(logic [15:0] old, logic [15:0] wr);
    return (wr[9:0] < 10'd4) ? old : {6'b0, wr[9:0]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic waitIrq(input int t0, input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq) begin at = cyc - t0; break; end
    end
  endtask

  task automatic waitRst(input int t0, input int limit, output int at, output int irqSeen);
    at = -1; irqSeen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq) irqSeen = 1;
      if (rstReq) begin at = cyc - t0; break; end
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    logic [15:0] d;
    logic [15:0] model;
    int t0, at, seen;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 rstReq", rstReq, 0);
    rd(5'h04, d); check("R1 control", d, 16'h0801);
    rd(5'h06, d); check("R1 init", d, 16'h0004);
    rd(5'h02, d); check("R1 status", d, 16'h0000);
    rd(5'h00, d); check("R1 count", d, 16'h0004);

    // R10 unmapped offsets
    rd(5'h0A, d); check("R10 unmapped read", d, 0);
    wr(5'h0A, 16'hFFFF);
    wr(5'h1E, 16'hFFFF);
    rd(5'h04, d); check("R10 control untouched", d, 16'h0801);
    rd(5'h06, d); check("R10 init untouched", d, 16'h0004);

    // R2 directed
    model = 16'h0004;
    wr(5'h06, 16'hFC55); model = nextInit(model, 16'hFC55);
    rd(5'h06, d); check("R2 upper bits dropped", d, 16'h0055);
    wr(5'h06, 16'h0002);
    rd(5'h06, d); check("R2 value 2 ignored", d, 16'h0055);
    wr(5'h06, 16'h0003);
    rd(5'h06, d); check("R2 value 3 ignored", d, 16'h0055);
    wr(5'h06, 16'h0004); model = 16'h0004;
    rd(5'h06, d); check("R2 floor accepted", d, 16'h0004);

    // R2 / R3 random
    for (int k = 0; k < 40; k++) begin
      logic [15:0] v;
      v = 16'($urandom);
      if (k % 3 == 0) v[9:0] = 10'($urandom % 4);
      wr(5'h06, v); model = nextInit(model, v);
      rd(5'h06, d); check("R2 random init", d, model);
      wr(5'h00, 16'($urandom));
      rd(5'h00, d); check("R3 reload any data", d, model);
    end

    // R4 / R5: halted hold, then partial countdown
    wr(5'h06, 16'd7);
    wr(5'h00, 16'h0000);
    repeat (50) @(negedge clk);
    rd(5'h00, d); check("R4 halted count", d, 7);
    wr(5'h04, 16'h0001);
    repeat (2 * DIV) @(negedge clk);
    wr(5'h04, 16'h0801);
    rd(5'h00, d); check("R5 two ticks", d, 5);
    repeat (40) @(negedge clk);
    rd(5'h00, d); check("R4 hold after halt", d, 5);
    rd(5'h04, d); check("R4 halt readback", d, 16'h0801);

    // R5 / R6 / R7 full run with masks cleared
    wr(5'h06, 16'(N));
    wr(5'h00, 16'h0000);
    wr(5'h02, 16'h0003);
    wr(5'h04, 16'h0000);
    t0 = cyc;
    waitIrq(t0, 4 * M, at);
    check("R5 first expiry time", at, M);
    check("R6 irq high", irq, 1);
    rd(5'h00, d); check("R5 count reloaded", d, N);
    check("R6 irq one clock", irq, 0);
    rd(5'h02, d); check("R6 status first", d, 16'h0001);
    waitRst(t0, 4 * M, at, seen);
    check("R7 second expiry time", at, 2 * M);
    check("R7 no irq on second", seen, 0);
    rd(5'h02, d); check("R7 status both", d, 16'h0003);

    // R8 reset mask
    wr(5'h04, 16'h0001);
    check("R8 masked", rstReq, 0);
    rd(5'h04, d); check("R8 readback", d, 16'h0001);
    wr(5'h04, 16'h0800);
    check("R8 unmasked", rstReq, 1);

    // R9 write-one-to-clear (halted)
    wr(5'h02, 16'h0000);
    rd(5'h02, d); check("R9 zero write keeps", d, 16'h0003);
    check("R9 rstReq kept", rstReq, 1);
    wr(5'h02, 16'h0002);
    check("R9 clear second", rstReq, 0);
    rd(5'h02, d); check("R9 first remains", d, 16'h0001);
    wr(5'h02, 16'h0001);
    rd(5'h02, d); check("R9 all clear", d, 0);

    // R6: warning cleared in time gives a second irq, no reset
    wr(5'h00, 16'h0000);
    wr(5'h04, 16'h0000);
    t0 = cyc;
    waitIrq(t0, 4 * M, at);
    check("R6 rerun expiry time", at, M);
    wr(5'h02, 16'h0001);
    waitIrq(t0, 4 * M, at);
    check("R6 second irq after clear", at, 2 * M);
    check("R7 no reset after clear", rstReq, 0);
    wr(5'h04, 16'h0801);

    finishRun();
  end
endmodule